// File: doc/BRIEF.md
# Attenuating Second-Order Sigma-Delta Bit Stream Generator

This block sits at the end of a voice receive path and turns one 13-bit signed audio word per frame into a 1-bit stream for a single-bit DAC. With each word comes a 3-bit attenuation code that picks one of eight gains, 3 dB apart. The block scales the word by that gain and latches the result. The latched value is then fed, unchanged, to a second-order error-feedback modulator for every oversampled step until the next word arrives. In effect the latch is a zero-order hold that stands in for an interpolation filter.

The modulator advances only on cycles where the oversampling enable is high. At an 8 kHz frame rate with an oversampling ratio of 128, the enable is high at 1.024 MHz. The loop shapes the quantisation error with (1 - z^-1)^2. It keeps two saturating error registers, so an overloaded input clips the loop state instead of wrapping it.

Top module: `sdm_att_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, `bit_out` is 0, the held sample is 0 and both error registers are 0.
- R2: The held sample is reloaded only at a rising clock edge where `smp_vld` is 1. While `smp_vld` is 0, changes on `smp_data` or `att_code` have no effect on the bit stream.
- R3: The held value is floor(`smp_data` * G / 32768). G is the 16-bit unsigned gain selected by `att_code`: 0 gives 32768, 1 gives 23198, 2 gives 16423, 3 gives 11627, 4 gives 8231, 5 gives 5827, 6 gives 4125 and 7 gives 2920. These are 0 dB down to -21 dB in 3 dB steps.
- R4: Code 0 passes the sample through exactly, including -4096.
- R5: On each enabled step, with held value h and errors e1 (newest) and e2, the block computes v = sat(h - 2*e1 + e2). The new bit is 1 when v >= 0. The level q is +4096 for a 1 and -4096 for a 0. The new error is sat(q - v), which moves into e1 while the old e1 moves into e2. The function sat clamps a value to the signed 18-bit range.
- R6: On a cycle where `os_en` is 0, `bit_out` and both error registers keep their values.
- R7: With a zero held value straight from reset, the stream is 1,0,0,1 and repeats with period 4, so ones and zeros have equal density.
- R8: Over 1024 enabled steps with a constant held value h, the count of ones is within 6 of 512*(1 + h/4096).
- R9: A held value of -4096 from a zero loop state gives an unbroken stream of zeros, with no wrap of the loop state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Loads a new sample and attenuation code |
| smp_data | input | 13 | Signed two's-complement audio word |
| att_code | input | 3 | Attenuation step, 0 = 0 dB, 7 = -21 dB |
| os_en | input | 1 | Oversampled step enable |
| bit_out | output | 1 | Modulator output bit |

## Verification
The scaled value is never visible at a port. An error of one LSB in it changes only the long-run shape of the stream, not the next bit. The bench therefore runs an exact integer model of the loop alongside the design and never resets between samples. It sweeps every attenuation code over a strided set of sample values and compares each output bit. Any mismatch in the hold value or in the loop state then shows up as a divergence a few steps later.

// File: rtl/sdm_att_pkg.sv
package sdm_att_pkg;

   localparam int GAIN_W    = 16;
   localparam int GAIN_FRAC = 15;
   localparam int N_STEPS   = 8;

   // 10^(-3k/20) in unsigned Q1.15
   function automatic logic [GAIN_W-1:0] att_gain(input int idx);
      logic [GAIN_W-1:0] g;
      case (idx)
         0:       g = 16'd32768;
         1:       g = 16'd23198;
         2:       g = 16'd16423;
         3:       g = 16'd11627;
         4:       g = 16'd8231;
         5:       g = 16'd5827;
         6:       g = 16'd4125;
         default: g = 16'd2920;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/sdm_att_scaler.sv
module sdm_att_scaler
   import sdm_att_pkg::*;
#(
   parameter int DATA_W = 13,
   parameter int CODE_W = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     smp_vld,
   input  logic signed [DATA_W-1:0] smp_data,
   input  logic [CODE_W-1:0]        att_code,
   output logic signed [DATA_W-1:0] held
);
   localparam int PROD_W  = DATA_W + GAIN_W + 1;
   localparam int N_CODES = 2 ** CODE_W;

   generate
      if (N_CODES != N_STEPS) begin : g_bad_code_w
         $error("sdm_att_scaler: CODE_W must select exactly %0d gains", N_STEPS);
      end
      if (DATA_W < 4) begin : g_bad_data_w
         $error("sdm_att_scaler: DATA_W too small");
      end
   endgenerate

   logic [GAIN_W-1:0] gain_lut [N_CODES];

   generate
      for (genvar gi = 0; gi < N_CODES; gi++) begin : g_lut
         assign gain_lut[gi] = att_gain(gi);
      end
   endgenerate

   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] shifted;
   logic signed [DATA_W-1:0] scaled;

   always_comb begin
      prod    = $signed({{(PROD_W-DATA_W){smp_data[DATA_W-1]}}, smp_data})
              * $signed({{(PROD_W-GAIN_W){1'b0}}, gain_lut[att_code]});
      shifted = prod >>> GAIN_FRAC;
      scaled  = shifted[DATA_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       held <= '0;
      else if (smp_vld) held <= scaled;
   end

   a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> $stable(held));

   a_r4_unity_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && att_code == '0) |=> held == $past(smp_data));

   a_r3_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld |=> ($past(smp_data) >= 0) ? (held >= 0 && held <= $past(smp_data))
                                         : (held <= 0 && held >= $past(smp_data)));

endmodule

// File: rtl/sdm_ef2_loop.sv
module sdm_ef2_loop #(
   parameter int DATA_W = 13,
   parameter int ACC_W  = 18
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     step,
   input  logic signed [DATA_W-1:0] h_in,
   output logic                     bit_o
);
   localparam int SUM_W = ACC_W + 3;
   localparam logic signed [SUM_W-1:0] FS   = SUM_W'(2 ** (DATA_W - 1));
   localparam logic signed [SUM_W-1:0] SMAX = SUM_W'(2 ** (ACC_W - 1) - 1);
   localparam logic signed [SUM_W-1:0] SMIN = -SMAX - 1;

   generate
      if (ACC_W < DATA_W + 5) begin : g_bad_acc_w
         $error("sdm_ef2_loop: ACC_W must be at least DATA_W+5");
      end
   endgenerate

   logic signed [ACC_W-1:0] e1, e2;
   logic signed [SUM_W-1:0] h_x, v_raw, v_sat, q_lvl, e_raw, e_sat;
   logic                    bit_nx;

   function automatic logic signed [SUM_W-1:0] clamp(input logic signed [SUM_W-1:0] x);
      if (x > SMAX)      return SMAX;
      else if (x < SMIN) return SMIN;
      else               return x;
   endfunction

   always_comb begin
      h_x    = $signed({{(SUM_W-DATA_W){h_in[DATA_W-1]}}, h_in});
      v_raw  = h_x
             - ($signed({{(SUM_W-ACC_W){e1[ACC_W-1]}}, e1}) <<< 1)
             + $signed({{(SUM_W-ACC_W){e2[ACC_W-1]}}, e2});
      v_sat  = clamp(v_raw);
      bit_nx = (v_sat >= 0);
      q_lvl  = bit_nx ? FS : -FS;
      e_raw  = q_lvl - v_sat;
      e_sat  = clamp(e_raw);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e1    <= '0;
         e2    <= '0;
         bit_o <= 1'b0;
      end else if (step) begin
         e1    <= e_sat[ACC_W-1:0];
         e2    <= e1;
         bit_o <= bit_nx;
      end
   end

   a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> ($stable(bit_o) && $stable(e1) && $stable(e2)));

   a_r5_delay_chain: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> e2 == $past(e1));

endmodule

// File: rtl/sdm_att_top.sv
module sdm_att_top #(
   parameter int DATA_W = 13,
   parameter int CODE_W = 3,
   parameter int ACC_W  = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_vld,
   input  logic [DATA_W-1:0] smp_data,
   input  logic [CODE_W-1:0] att_code,
   input  logic              os_en,
   output logic              bit_out
);
   logic signed [DATA_W-1:0] held;

   sdm_att_scaler #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_scaler (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_vld  (smp_vld),
      .smp_data ($signed(smp_data)),
      .att_code (att_code),
      .held     (held)
   );

   sdm_ef2_loop #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_loop (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (os_en),
      .h_in  (held),
      .bit_o (bit_out)
   );

   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !bit_out);

endmodule

// File: tb/sdm_att_top_tb.sv
module sdm_att_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_vld = 1'b0;
   logic [12:0] smp_data = '0;
   logic [2:0]  att_code = '0;
   logic        os_en = 1'b0;
   logic        bit_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // bench model of the loop (R5)
   longint m_h  = 0;
   longint m_e1 = 0;
   longint m_e2 = 0;

   always #5 clk = ~clk;

   sdm_att_top u_dut (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
      .att_code(att_code), .os_en(os_en), .bit_out(bit_out)
   );

   function automatic longint gain_of(input int c);
      longint tbl [8] = '{32768, 23198, 16423, 11627, 8231, 5827, 4125, 2920};
      return tbl[c];
   endfunction

   function automatic longint sat18(input longint x);
      if (x > 131071)  return 131071;
      if (x < -131072) return -131072;
      return x;
   endfunction

   function automatic bit model_step();
      longint v, q, e;
      bit b;
      v = sat18(m_h - 2 * m_e1 + m_e2);
      b = (v >= 0);
      q = b ? 4096 : -4096;
      e = sat18(q - v);
      m_e2 = m_e1;
      m_e1 = e;
      return b;
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic load(input int s, input int c);
      @(negedge clk);
      smp_vld  = 1'b1;
      smp_data = 13'(s);
      att_code = 3'(c);
      @(negedge clk);
      smp_vld  = 1'b0;
      m_h = (longint'(s) * gain_of(c)) >>> 15;
   endtask

   // one enabled step; compare the new bit with the model
   task automatic step_chk(input string req, output bit b);
      bit exp_b;
      os_en = 1'b1;
      @(negedge clk);
      os_en = 1'b0;
      exp_b = model_step();
      b = bit_out;
      check(bit_out == exp_b, req, bit_out, exp_b);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      bit b;
      int ones;
      int pat [4] = '{1, 0, 0, 1};

      repeat (3) @(negedge clk);
      check(bit_out == 1'b0, "R1 reset bit", bit_out, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(bit_out == 1'b0, "R1 after release", bit_out, 0);

      // R7: zero input from reset
      for (int i = 0; i < 12; i++) begin
         step_chk("R7 R5 zero pattern", b);
         check(b == pat[i % 4], "R7 period-4", b, pat[i % 4]);
      end

      // R6: idle cycles hold the bit; R2: data changes without strobe ignored
      load(1500, 0);
      step_chk("R5 pre-idle", b);
      for (int i = 0; i < 6; i++) begin
         smp_data = 13'(-3000 + i * 777);
         att_code = 3'(i);
         @(negedge clk);
         check(bit_out == b, "R6 idle hold", bit_out, b);
      end
      for (int i = 0; i < 20; i++) step_chk("R2 ignored without strobe", b);

      // R3/R4: sweep every code over strided samples, exact stream compare
      for (int c = 0; c < 8; c++) begin
         for (int s = -4096; s <= 4095; s += 31) begin
            load(s, c);
            for (int k = 0; k < 16; k++)
               step_chk((c == 0) ? "R4 R5 unity sweep" : "R3 R5 gain sweep", b);
         end
      end

      // R9: negative full scale from zero loop state
      rst_n = 1'b0;
      m_e1 = 0; m_e2 = 0; m_h = 0;
      @(negedge clk);
      rst_n = 1'b1;
      load(-4096, 0);
      for (int i = 0; i < 64; i++) begin
         step_chk("R9 R5 neg full scale", b);
         check(b == 1'b0, "R9 all zeros", b, 0);
      end

      // R8: density for several held values
      for (int t = 0; t < 5; t++) begin
         int sv [5] = '{0, 2048, -3000, 4095, 4095};
         int cv [5] = '{0, 0, 0, 7, 2};
         longint hexp, target;
         load(sv[t], cv[t]);
         hexp = (longint'(sv[t]) * gain_of(cv[t])) >>> 15;
         target = 512 + (hexp * 512) / 4096;
         ones = 0;
         for (int i = 0; i < 1024; i++) begin
            step_chk("R8 R5 density stream", b);
            ones += b;
         end
         check((ones >= target - 6) && (ones <= target + 6), "R8 density", ones, target);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule